// File: doc/BRIEF.md
# Iterative Radix Digit Converter

This block turns an unsigned binary integer into a string of digits in a selectable base: binary, octal, decimal or hexadecimal. It works the way the pencil method does. The value is divided by the base. The remainder becomes a digit, and the quotient is fed back in as the next dividend. The process stops once a quotient of zero appears. The division itself is a serial restoring shift-and-subtract loop that settles one quotient bit per clock. The block therefore trades speed for a very small datapath.

A caller pulses `start` with the value, the base and the wanted digit order. Digits leave on a valid-qualified output with a marker on the final digit. In least-significant-first order each digit is sent as soon as its division finishes. In most-significant-first order the digits are pushed onto an internal stack while the divisions run. They are then popped out back to back once the quotient reaches zero.

Top module: `radix_conv`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `busy` and `dig_valid` are low.
- R2: `radix_sel` selects the base as follows: 0 is base 2, 1 is base 8, 2 is base 10, 3 is base 16. Each digit on `dig` is an unsigned binary number smaller than the selected base.
- R3: When `msd_first` is 0, the digits arrive least significant first. They equal the remainders of repeatedly dividing the value by the base, and the sequence ends at the division whose quotient is zero.
- R4: When `msd_first` is 1, the same digits arrive in reverse order (most significant first) on consecutive clock cycles.
- R5: The number of digits is the minimal digit count of the value in the selected base. `dig_last` is high only together with the final digit.
- R6: An input value of 0 gives exactly one digit, 0, with `dig_last` high.
- R7: A `start` pulse while `busy` is high is ignored. The running conversion's digits are unchanged, and no second conversion follows.
- R8: `busy` is high in the cycle after an accepted `start` and stays high through the cycle that shows the final digit. It is low in the cycle after that.
- R9: Each division takes VAL_W clock cycles. In least-significant-first order, the first digit is valid in the cycle after the (VAL_W+1)-th rising edge that follows the edge which accepted `start`. Later digits follow every VAL_W+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion; accepted only while idle |
| value_in | input | VAL_W | Unsigned value to convert, sampled with an accepted start |
| radix_sel | input | 2 | Base select: 0 binary, 1 octal, 2 decimal, 3 hexadecimal |
| msd_first | input | 1 | 1 gives most significant digit first, 0 gives least significant first |
| busy | output | 1 | Conversion in progress |
| dig_valid | output | 1 | `dig` carries a digit this cycle |
| dig | output | 4 | Digit value, 0 to base-1 |
| dig_last | output | 1 | Marks the final digit of the conversion |

## Verification
The bench builds the converter with VAL_W = 8, so the stack depth is also 8. That puts all 256 input values within reach under every base and both digit orders. The sweep includes zero, the largest value, and every point where the digit count grows. At this width a full binary conversion fills the stack exactly. This exercises the point where the stack is full and then read out completely. Latency and digit spacing are measured against the eight-cycle division. A subset of runs pulses `start` with different operands partway through, to show that the pulse changes nothing.

// File: rtl/radix_conv_pkg.sv
package radix_conv_pkg;

   localparam int DIGIT_W = 4;
   localparam int DIV_W   = 5;

   typedef enum logic [1:0] {
      RAD_BIN = 2'd0,
      RAD_OCT = 2'd1,
      RAD_DEC = 2'd2,
      RAD_HEX = 2'd3
   } radix_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DIV   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_DONE  = 2'd3
   } conv_state_e;

   function automatic logic [DIV_W-1:0] radix_divisor(input radix_e r);
      case (r)
         RAD_BIN: radix_divisor = DIV_W'(2);
         RAD_OCT: radix_divisor = DIV_W'(8);
         RAD_DEC: radix_divisor = DIV_W'(10);
         default: radix_divisor = DIV_W'(16);
      endcase
   endfunction

endpackage

// File: rtl/radix_serial_div.sv
module radix_serial_div #(
   parameter int VAL_W = 16,
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [VAL_W-1:0] dividend,
   input  logic [DIV_W-1:0] divisor,
   output logic             done,
   output logic [VAL_W-1:0] quot,
   output logic [DIV_W-1:0] rem
);

   localparam int CNT_W = $clog2(VAL_W + 1);

   generate
      if (VAL_W < 2) begin : g_bad_width
         $error("radix_serial_div: VAL_W must be at least 2");
      end
      if (DIV_W < 2) begin : g_bad_div
         $error("radix_serial_div: DIV_W must be at least 2");
      end
   endgenerate

   logic [VAL_W-1:0] quot_q;
   logic [DIV_W-1:0] rem_q;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   logic [DIV_W-1:0] partial;
   logic             fits;

   // Bring the next dividend bit down beside the running remainder.
   assign partial = {rem_q[DIV_W-2:0], quot_q[VAL_W-1]};
   assign fits    = (partial >= div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quot_q <= '0;
         rem_q  <= '0;
         div_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (load) begin
         quot_q <= dividend;
         rem_q  <= '0;
         div_q  <= divisor;
         cnt_q  <= CNT_W'(VAL_W);
         done_q <= 1'b0;
      end else if (cnt_q != '0) begin
         quot_q <= {quot_q[VAL_W-2:0], fits};
         rem_q  <= fits ? (partial - div_q) : partial;
         cnt_q  <= cnt_q - CNT_W'(1);
         done_q <= (cnt_q == CNT_W'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign done = done_q;
   assign quot = quot_q;
   assign rem  = rem_q;

endmodule

// File: rtl/radix_digit_stack.sv
module radix_digit_stack #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic [DATA_W-1:0]            din,
   input  logic                         pop,
   output logic [DATA_W-1:0]            dout,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("radix_digit_stack: DEPTH must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] slot [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (push && !clr && (cnt_q == CNT_W'(i))) begin
               q <= din;
            end
         end
         assign slot[i] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (push && (cnt_q != CNT_W'(DEPTH))) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end else if (pop && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   // Top of stack is the most recently written slot.
   always_comb begin
      dout = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cnt_q == CNT_W'(i + 1)) dout = slot[i];
      end
   end

   assign count = cnt_q;
   assign full  = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/radix_conv.sv
module radix_conv
   import radix_conv_pkg::*;
#(
   parameter int VAL_W = 16,
   parameter int DEPTH = VAL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [VAL_W-1:0]   value_in,
   input  logic [1:0]         radix_sel,
   input  logic               msd_first,
   output logic               busy,
   output logic               dig_valid,
   output logic [DIGIT_W-1:0] dig,
   output logic               dig_last
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (VAL_W < 2) begin : g_bad_width
         $error("radix_conv: VAL_W must be at least 2");
      end
      if (DEPTH < VAL_W) begin : g_bad_depth
         $error("radix_conv: DEPTH must hold VAL_W binary digits");
      end
   endgenerate

   conv_state_e        state_q;
   radix_e             radix_q;
   logic               msd_q;
   logic               dig_valid_q;
   logic [DIGIT_W-1:0] dig_q;
   logic               dig_last_q;

   logic               accept;
   logic               div_load;
   logic [VAL_W-1:0]   div_dividend;
   logic [DIV_W-1:0]   div_divisor;
   logic               div_done;
   logic [VAL_W-1:0]   div_quot;
   logic [DIV_W-1:0]   div_rem;
   logic               quot_zero;

   logic               stk_push;
   logic               stk_pop;
   logic [DIGIT_W-1:0] stk_top;
   logic [CNT_W-1:0]   stk_count;
   logic               stk_full;

   assign accept    = start && (state_q == ST_IDLE);
   assign quot_zero = (div_quot == '0);

   // The divider is reloaded with the quotient the cycle it reports done.
   assign div_load     = accept || ((state_q == ST_DIV) && div_done && !quot_zero);
   assign div_dividend = accept ? value_in : div_quot;
   assign div_divisor  = radix_divisor(accept ? radix_e'(radix_sel) : radix_q);

   assign stk_push = (state_q == ST_DIV) && div_done && msd_q;
   assign stk_pop  = (state_q == ST_DRAIN);

   radix_serial_div #(
      .VAL_W (VAL_W),
      .DIV_W (DIV_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (div_load),
      .dividend (div_dividend),
      .divisor  (div_divisor),
      .done     (div_done),
      .quot     (div_quot),
      .rem      (div_rem)
   );

   radix_digit_stack #(
      .DEPTH  (DEPTH),
      .DATA_W (DIGIT_W)
   ) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .push  (stk_push),
      .din   (div_rem[DIGIT_W-1:0]),
      .pop   (stk_pop),
      .dout  (stk_top),
      .count (stk_count),
      .full  (stk_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         radix_q     <= RAD_BIN;
         msd_q       <= 1'b0;
         dig_valid_q <= 1'b0;
         dig_q       <= '0;
         dig_last_q  <= 1'b0;
      end else begin
         dig_valid_q <= 1'b0;
         dig_last_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  radix_q <= radix_e'(radix_sel);
                  msd_q   <= msd_first;
                  state_q <= ST_DIV;
               end
            end
            ST_DIV: begin
               if (div_done) begin
                  if (!msd_q) begin
                     dig_valid_q <= 1'b1;
                     dig_q       <= div_rem[DIGIT_W-1:0];
                     dig_last_q  <= quot_zero;
                  end
                  if (quot_zero) begin
                     state_q <= msd_q ? ST_DRAIN : ST_DONE;
                  end
               end
            end
            ST_DRAIN: begin
               dig_valid_q <= 1'b1;
               dig_q       <= stk_top;
               dig_last_q  <= (stk_count == CNT_W'(1));
               if (stk_count == CNT_W'(1)) begin
                  state_q <= ST_DONE;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign dig_valid = dig_valid_q;
   assign dig       = dig_q;
   assign dig_last  = dig_last_q;

endmodule

// File: rtl/radix_conv_chk.sv
module radix_conv_chk #(
   parameter int VAL_W = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       dig_valid,
   input logic [3:0] dig,
   input logic       dig_last,
   input logic [1:0] radix_q,
   input logic       stk_push,
   input logic       stk_full
);

   logic [4:0] base_now;
   always_comb begin
      case (radix_q)
         2'd0:    base_now = 5'd2;
         2'd1:    base_now = 5'd8;
         2'd2:    base_now = 5'd10;
         default: base_now = 5'd16;
      endcase
   end

   assert_busy_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_valid_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dig_valid |-> busy);

   assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_valid && dig_last) |=> !busy);

   assert_last_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_valid && dig_last) |=> !dig_valid);

   assert_last_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dig_last |-> dig_valid);

   assert_digit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dig_valid |-> ({1'b0, dig} < base_now));

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stk_push |-> !stk_full);

   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> $stable(radix_q));

endmodule

bind radix_conv radix_conv_chk #(
   .VAL_W (VAL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .dig_valid (dig_valid),
   .dig       (dig),
   .dig_last  (dig_last),
   .radix_q   (radix_q),
   .stk_push  (stk_push),
   .stk_full  (stk_full)
);

// File: tb/radix_conv_tb.sv
module radix_conv_tb;

   localparam int  VW         = 8;
   localparam time CLK_PERIOD = 10;
   localparam int  RUN_LIMIT  = 4000;
   localparam int  WATCHDOG   = 190000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [VW-1:0] value_in = '0;
   logic [1:0]    radix_sel = '0;
   logic          msd_first = 1'b0;
   logic          busy;
   logic          dig_valid;
   logic [3:0]    dig;
   logic          dig_last;

   int n_checks = 0;
   int n_err    = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   radix_conv #(
      .VAL_W (VW),
      .DEPTH (VW)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .value_in  (value_in),
      .radix_sel (radix_sel),
      .msd_first (msd_first),
      .busy      (busy),
      .dig_valid (dig_valid),
      .dig       (dig),
      .dig_last  (dig_last)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_conv(input int v, input int rs, input bit msd, input bit poke);
      int    base;
      int    t;
      int    exp_d[VW + 1];
      int    exp_n;
      int    got_d[VW + 1];
      int    got_k[VW + 1];
      int    got_n;
      int    k;
      bit    seen_last;
      bit    busy_ok;
      bit    range_ok;
      bit    match;
      bit    timing_ok;
      int    bad_idx;
      int    want;
      string tag;

      base = (rs == 0) ? 2 : (rs == 1) ? 8 : (rs == 2) ? 10 : 16;
      exp_n = 0;
      t = v;
      do begin
         exp_d[exp_n] = t % base;
         t = t / base;
         exp_n++;
      end while (t != 0);

      @(negedge clk);
      start     = 1'b1;
      value_in  = VW'(v);
      radix_sel = 2'(rs);
      msd_first = msd;
      @(negedge clk);
      start     = 1'b0;
      value_in  = ~VW'(v);
      radix_sel = 2'(rs) ^ 2'b01;
      msd_first = !msd;
      // R8: busy rises right after the accepted start
      check(busy == 1'b1, "R8", "busy after start", int'(busy), 1);

      got_n = 0;
      k = 0;
      seen_last = 1'b0;
      busy_ok = 1'b1;
      range_ok = 1'b1;
      while (!seen_last && k < RUN_LIMIT) begin
         @(negedge clk);
         k++;
         if (dig_valid) begin
            if (!busy) busy_ok = 1'b0;
            if (int'(dig) >= base) range_ok = 1'b0;
            if (got_n <= VW) begin
               got_d[got_n] = int'(dig);
               got_k[got_n] = k;
            end
            got_n++;
            if (dig_last) seen_last = 1'b1;
         end
         if (poke && k == 3) begin
            start     = 1'b1;
            value_in  = VW'(v) ^ VW'(8'hA5);
            radix_sel = 2'(rs) ^ 2'b11;
            msd_first = !msd;
         end else if (poke && k == 4) begin
            start = 1'b0;
         end
      end

      check(seen_last, "R5", "final digit marker seen", int'(seen_last), 1);
      check(got_n == exp_n, "R5", "digit count", got_n, exp_n);
      check(range_ok, "R2", "every digit below base", int'(range_ok), 1);
      check(busy_ok, "R8", "busy high with each digit", int'(busy_ok), 1);

      match = (got_n == exp_n);
      bad_idx = -1;
      for (int i = 0; i < exp_n && i <= VW && match; i++) begin
         want = msd ? exp_d[exp_n - 1 - i] : exp_d[i];
         if (got_d[i] != want) begin
            match = 1'b0;
            bad_idx = i;
         end
      end
      if (poke)        tag = "R7";
      else if (v == 0) tag = "R6";
      else if (msd)    tag = "R4";
      else             tag = "R3";
      if (bad_idx >= 0) begin
         want = msd ? exp_d[exp_n - 1 - bad_idx] : exp_d[bad_idx];
         check(1'b0, tag, $sformatf("digit %0d of value %0d base %0d", bad_idx, v, base),
               got_d[bad_idx], want);
      end else begin
         check(match, tag, $sformatf("digits of value %0d base %0d", v, base), got_n, exp_n);
      end

      if (match) begin
         timing_ok = 1'b1;
         if (msd) begin
            for (int i = 1; i < got_n; i++)
               if (got_k[i] != got_k[i-1] + 1) timing_ok = 1'b0;
            check(timing_ok, "R4", "back-to-back readout", got_k[got_n-1] - got_k[0], got_n - 1);
         end else begin
            if (got_k[0] != VW + 1) timing_ok = 1'b0;
            for (int i = 1; i < got_n; i++)
               if (got_k[i] != got_k[i-1] + VW + 1) timing_ok = 1'b0;
            check(timing_ok, "R9", "first digit cycle", got_k[0], VW + 1);
         end
      end

      @(negedge clk);
      // R8 and R7: idle one cycle after the last digit, no extra run started
      check(busy == 1'b0, "R8", "busy low after final digit", int'(busy), 0);
      check(dig_valid == 1'b0, "R7", "no digit after final", int'(dig_valid), 0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_err++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
      check(dig_valid == 1'b0, "R1", "dig_valid in reset", int'(dig_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
      check(dig_valid == 1'b0, "R1", "dig_valid after reset", int'(dig_valid), 0);

      for (int rs = 0; rs < 4; rs++) begin
         for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < (1 << VW); v++) begin
               run_conv(v, rs, m[0], (v % 7) == 3);
            end
         end
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule